// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm

This block keeps a free-running 48-bit count of a 32768 Hz time base. A one-cycle tick enable advances it. Software reaches the count and a 48-bit alarm compare value through a small synchronous halfword port. Each 48-bit quantity is split into three 16-bit halfwords. The 15 least significant bits hold sub-second ticks, so the whole-second value sits in count bits [47:15]. When software stores a time in seconds, it puts second bit 0 in bit 15 of the low halfword and clears bits [14:0] of that halfword.

When the count moves onto the compare value, the block raises an alarm flag in a status register that sits in a second register window. Software clears that flag by writing a one to it. The interrupt output combines each status flag with its own enable input.

Reads return the live register contents and are never latched. A carry that lands between two halfword reads can therefore give software a torn value. Software guards against this by reading the value twice and comparing the two results.

Top module: `elt_timer_top`

## Requirements
- R1: In window 0, the counter halfwords sit at offsets 0x00 (low), 0x02 (middle) and 0x04 (high), and each one reads and writes as 16 bits. A seconds value S is stored as low = {S[0], 15'b0}, middle = S[16:1] and high = S[32:17], and {high, middle, low[15]} reads back as S.
- R2: In every clock cycle with `tick_en` high and no counter write, the 48-bit count advances by one. The carry crosses halfword boundaries, and the count wraps from all ones to zero.
- R3: With `tick_en` low and no counter write, the count holds its value.
- R4: A write to one counter halfword shows up after the next clock edge. In that cycle it replaces the increment for the written halfword only, and the other halfwords still take their incremented value.
- R5: The alarm compare halfwords sit in window 0 at offsets 0x08 (low), 0x0a (middle) and 0x0c (high), with the same bit layout as the counter, and they read back what was written.
- R6: On the clock edge where the count changes to a value equal to the compare value, bit 0 (the alarm flag) of the status register at window 1, offset 0x1e, becomes 1.
- R7: The alarm flag is not set while the count stays unchanged, even when it equals the compare value. This includes a compare write that equals the current count.
- R8: Writing the status register with data bit 0 = 1 clears the alarm flag, and writing 0 in that bit leaves the flag as it is. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq` is high exactly when a status flag is 1 and its `flag_en` bit is 1.
- R10: Reads are combinational and not latched, so read data follows the addressed register in the same cycle. Unmapped offsets in either window read as 0, and writes to them have no effect.
- R11: A synchronous active-low reset clears the count, the compare value and the status flag to 0, and `irq` reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe from the 32768 Hz time base |
| bus_win | input | 1 | Register window select: 0 selects counter/compare, 1 selects status |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| flag_en | input | 1 | Per-flag interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The counter runs through several carry patterns: a single tick that crosses the seconds bit, a carry that ripples through two halfwords, a full 48-bit wrap, and a tick that lands in the same cycle as a halfword write. Together these separate a correct 48-bit increment from a per-halfword increment or from a write that overrides the whole word. The alarm is approached one tick at a time, so a flag that rises a cycle early or late shows up. The bench then holds the count on the compare value and rewrites an equal compare value, which separates an edge-triggered match from a level-triggered one. A set and a clear are forced into the same cycle to show the set winning. A read, a tick, and a second read form a torn value that a double read detects.

// File: rtl/elt_pkg.sv
`timescale 1ns/1ps
// Package elt_pkg
// Shared sizes and register offsets for the elapsed-time counter.
// Assumes byte offsets that address 16-bit halfwords on even addresses.
package elt_pkg;
    localparam int HW_W      = 16;   // halfword width
    localparam int NUM_HW    = 3;    // halfwords per counter / compare value
    localparam int ADDR_W    = 5;    // byte offset width inside a window
    localparam int NUM_FLAGS = 1;    // status flags
    localparam int ALARM_BIT = 0;    // status bit driven by the compare
    localparam int CNT_BASE  = 0;    // window 0: counter halfwords
    localparam int CMP_BASE  = 8;    // window 0: compare halfwords
    localparam int STAT_OFF  = 30;   // window 1: status register (0x1e)
endpackage

// File: rtl/elt_counter.sv
`timescale 1ns/1ps
// Module elt_counter
// Multi-halfword tick counter. It adds tick_en to the full value each cycle,
// and a halfword write replaces only that halfword's next value.
// Assumes at most one halfword write per cycle (decoded by the top).
module elt_counter #(
    parameter int HW_W   = elt_pkg::HW_W,
    parameter int NUM_HW = elt_pkg::NUM_HW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_en,
    input  logic [NUM_HW-1:0]        wr_en,
    input  logic [HW_W-1:0]          wdata,
    output logic [HW_W*NUM_HW-1:0]   cnt_q,
    output logic [HW_W*NUM_HW-1:0]   cnt_next
);
    localparam int CNT_W = HW_W * NUM_HW;

    logic [CNT_W-1:0] cnt_inc;

    // Full-width increment so carries cross halfword boundaries
    assign cnt_inc = cnt_q + CNT_W'(tick_en);

    for (genvar i = 0; i < NUM_HW; i++) begin : g_hw
        // Per-halfword choice between the write data and the incremented value
        assign cnt_next[i*HW_W +: HW_W] = wr_en[i] ? wdata : cnt_inc[i*HW_W +: HW_W];

        // R4: a written halfword holds the write data after the edge
        a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[i] |=> (cnt_q[i*HW_W +: HW_W] == $past(wdata)));
    end

    // Counter register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    // R2: one tick and no write advances the value by one
    a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && (wr_en == '0)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R3: no tick and no write keeps the value
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && (wr_en == '0)) |=> $stable(cnt_q));
endmodule

// File: rtl/elt_compare.sv
`timescale 1ns/1ps
// Module elt_compare
// Holds the alarm compare value and flags the edge where the counter moves
// onto it. The match looks at the counter's next value, so the flag lands on
// the same edge as the counter update.
// Assumes cnt_next is the value the counter loads at the coming edge.
module elt_compare #(
    parameter int HW_W   = elt_pkg::HW_W,
    parameter int NUM_HW = elt_pkg::NUM_HW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_HW-1:0]        wr_en,
    input  logic [HW_W-1:0]          wdata,
    input  logic [HW_W*NUM_HW-1:0]   cnt_q,
    input  logic [HW_W*NUM_HW-1:0]   cnt_next,
    output logic [HW_W*NUM_HW-1:0]   cmp_q,
    output logic                     match_set
);
    for (genvar i = 0; i < NUM_HW; i++) begin : g_hw
        // Compare halfword register, loaded by its own write strobe
        always_ff @(posedge clk) begin
            if (!rst_n)       cmp_q[i*HW_W +: HW_W] <= '0;
            else if (wr_en[i]) cmp_q[i*HW_W +: HW_W] <= wdata;
        end

        // R5: a compare write is held after the edge
        a_r5_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[i] |=> (cmp_q[i*HW_W +: HW_W] == $past(wdata)));
    end

    // Edge-only match: the counter is changing and lands on the compare value
    always_comb begin
        match_set = (cnt_next != cnt_q) && (cnt_next == cmp_q);
    end

    // R6: after a match with no compare write, counter and compare agree
    a_r6_match_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (match_set && (wr_en == '0)) |=> (cnt_q == cmp_q));
endmodule

// File: rtl/elt_status.sv
`timescale 1ns/1ps
// Module elt_status
// Sticky status flags with write-one-to-clear and per-flag interrupt enable.
// Assumes set pulses are one cycle wide; a set beats a clear in the same cycle.
module elt_status #(
    parameter int NUM_FLAGS = elt_pkg::NUM_FLAGS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_vec,
    input  logic                 clr_wr,
    input  logic [NUM_FLAGS-1:0] clr_mask,
    input  logic [NUM_FLAGS-1:0] flag_en,
    output logic [NUM_FLAGS-1:0] flags_q,
    output logic                 irq
);
    logic [NUM_FLAGS-1:0] clr_vec;

    // Clear only the bits written as one, and only on a status write
    assign clr_vec = clr_wr ? clr_mask : '0;

    // Flag register: clear first, then set, so the set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_vec) | set_vec;
    end

    // Interrupt request from enabled flags
    assign irq = |(flags_q & flag_en);

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        // R6: a set pulse leaves the flag high
        a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[f] |=> flags_q[f]);
        // R8: a clear with no set drops the flag
        a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_mask[f] && !set_vec[f]) |=> !flags_q[f]);
        // R8: writing zero keeps a raised flag
        a_r8_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[f] && !(clr_wr && clr_mask[f])) |=> flags_q[f]);
    end

    // R9: no enables means no interrupt
    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en == '0) |-> !irq);
endmodule

// File: rtl/elt_timer_top.sv
`timescale 1ns/1ps
// Module elt_timer_top
// Elapsed-time counter with an alarm compare and a halfword register port.
// Window 0 holds the counter and compare halfwords, and window 1 holds status.
// Reads are combinational from live registers and are never snapshotted.
// Assumes tick_en is a one-cycle strobe from the 32768 Hz time base.
module elt_timer_top #(
    parameter int HW_W      = elt_pkg::HW_W,
    parameter int NUM_HW    = elt_pkg::NUM_HW,
    parameter int ADDR_W    = elt_pkg::ADDR_W,
    parameter int NUM_FLAGS = elt_pkg::NUM_FLAGS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 bus_win,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [HW_W-1:0]      bus_wdata,
    output logic [HW_W-1:0]      bus_rdata,
    input  logic [NUM_FLAGS-1:0] flag_en,
    output logic                 irq
);
    localparam int CNT_W = HW_W * NUM_HW;

    logic [NUM_HW-1:0]    cnt_wr;
    logic [NUM_HW-1:0]    cmp_wr;
    logic                 stat_wr;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     cnt_next;
    logic [CNT_W-1:0]     cmp_q;
    logic                 match_set;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flags_q;

    for (genvar i = 0; i < NUM_HW; i++) begin : g_dec
        // Halfword write strobes for counter and compare in window 0
        assign cnt_wr[i] = bus_we && !bus_win &&
                           (bus_addr == ADDR_W'(elt_pkg::CNT_BASE + 2*i));
        assign cmp_wr[i] = bus_we && !bus_win &&
                           (bus_addr == ADDR_W'(elt_pkg::CMP_BASE + 2*i));
    end

    // Status write strobe in window 1
    assign stat_wr = bus_we && bus_win && (bus_addr == ADDR_W'(elt_pkg::STAT_OFF));

    // Route the compare match to its status bit
    always_comb begin
        set_vec = '0;
        set_vec[elt_pkg::ALARM_BIT] = match_set;
    end

    elt_counter #(.HW_W(HW_W), .NUM_HW(NUM_HW)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wr_en    (cnt_wr),
        .wdata    (bus_wdata),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next)
    );

    elt_compare #(.HW_W(HW_W), .NUM_HW(NUM_HW)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cmp_wr),
        .wdata     (bus_wdata),
        .cnt_q     (cnt_q),
        .cnt_next  (cnt_next),
        .cmp_q     (cmp_q),
        .match_set (match_set)
    );

    elt_status #(.NUM_FLAGS(NUM_FLAGS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (stat_wr),
        .clr_mask (bus_wdata[NUM_FLAGS-1:0]),
        .flag_en  (flag_en),
        .flags_q  (flags_q),
        .irq      (irq)
    );

    // Live read multiplexer; unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        if (!bus_win) begin
            for (int i = 0; i < NUM_HW; i++) begin
                if (bus_addr == ADDR_W'(elt_pkg::CNT_BASE + 2*i))
                    bus_rdata = cnt_q[i*HW_W +: HW_W];
                if (bus_addr == ADDR_W'(elt_pkg::CMP_BASE + 2*i))
                    bus_rdata = cmp_q[i*HW_W +: HW_W];
            end
        end else if (bus_addr == ADDR_W'(elt_pkg::STAT_OFF)) begin
            bus_rdata = HW_W'(flags_q);
        end
    end

    // R7: the alarm flag only rises on a cycle where the count moved
    a_r7_rise_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_q[elt_pkg::ALARM_BIT]) |-> (cnt_q != $past(cnt_q)));

    // R11: reset leaves the count at zero
    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0));
endmodule

// File: tb/test_elt_timer_top.sv
`timescale 1ns/1ps
// Bench for elt_timer_top: a vector table for register access, then directed
// tests for counting, carries, alarm edges, clear priority, gating, torn reads
// and reset.
module test_elt_timer_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        we;
        logic        win;
        logic [4:0]  addr;
        logic [15:0] data;
        logic [3:0]  req;
    } vec_t;

    // Register access vectors: writes, then reads checked against data
    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 5'h00, 16'h8000, 4'd1},
        '{1'b1, 1'b0, 5'h02, 16'h1234, 4'd1},
        '{1'b1, 1'b0, 5'h04, 16'h0056, 4'd1},
        '{1'b0, 1'b0, 5'h00, 16'h8000, 4'd1},
        '{1'b0, 1'b0, 5'h02, 16'h1234, 4'd1},
        '{1'b0, 1'b0, 5'h04, 16'h0056, 4'd1},
        '{1'b1, 1'b0, 5'h08, 16'h1111, 4'd5},
        '{1'b1, 1'b0, 5'h0a, 16'h2222, 4'd5},
        '{1'b1, 1'b0, 5'h0c, 16'h3333, 4'd5},
        '{1'b0, 1'b0, 5'h08, 16'h1111, 4'd5},
        '{1'b0, 1'b0, 5'h0a, 16'h2222, 4'd5},
        '{1'b0, 1'b0, 5'h0c, 16'h3333, 4'd5},
        '{1'b0, 1'b0, 5'h06, 16'h0000, 4'd10},
        '{1'b1, 1'b0, 5'h0e, 16'hABCD, 4'd10},
        '{1'b0, 1'b0, 5'h0e, 16'h0000, 4'd10},
        '{1'b0, 1'b1, 5'h00, 16'h0000, 4'd10},
        '{1'b0, 1'b1, 5'h1e, 16'h0000, 4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_win = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [0:0]  flag_en = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    elt_timer_top i_elt_timer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_win   (bus_win),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .flag_en   (flag_en),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic win, input logic [4:0] addr, input logic [15:0] data);
        @(negedge clk);
        bus_win = win; bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic win, input logic [4:0] addr, output logic [15:0] data);
        @(negedge clk);
        bus_win = win; bus_addr = addr; bus_we = 1'b0;
        #1 data = bus_rdata;
    endtask

    task automatic set_count(input logic [15:0] lo, input logic [15:0] mid, input logic [15:0] hi);
        bus_write(1'b0, 5'h00, lo);
        bus_write(1'b0, 5'h02, mid);
        bus_write(1'b0, 5'h04, hi);
    endtask

    task automatic read_count(output logic [47:0] val);
        logic [15:0] lo, mid, hi;
        bus_read(1'b0, 5'h00, lo);
        bus_read(1'b0, 5'h02, mid);
        bus_read(1'b0, 5'h04, hi);
        val = {hi, mid, lo};
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic read_flag(output logic [15:0] val);
        bus_read(1'b1, 5'h1e, val);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, rd2;
        logic [47:0] cnt;
        logic [32:0] secs;
        logic [47:0] first_val, second_val;

        // R11: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        read_count(cnt);
        check("R11 count after reset", cnt, 48'h0);
        bus_read(1'b0, 5'h08, rd);
        check("R11 compare low after reset", {32'h0, rd}, 48'h0);
        read_flag(rd);
        check("R11 status after reset", {32'h0, rd}, 48'h0);
        check("R11 irq after reset", {47'h0, irq}, 48'h0);

        // Table of register accesses (R1, R5, R6, R10)
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].we) begin
                bus_write(VECS[v].win, VECS[v].addr, VECS[v].data);
            end else begin
                bus_read(VECS[v].win, VECS[v].addr, rd);
                check($sformatf("R%0d table vector %0d", VECS[v].req, v),
                      {32'h0, rd}, {32'h0, VECS[v].data});
            end
        end

        // R1: seconds layout, stored and recovered from count bits [47:15]
        secs = 33'h1_2345_6789;
        set_count({secs[0], 15'h0}, secs[16:1], secs[32:17]);
        read_count(cnt);
        check("R1 seconds recovered", {15'h0, cnt[47:15]}, {15'h0, secs});
        check("R1 sub-second bits zero", {33'h0, cnt[14:0]}, 48'h0);

        // R2: tick crosses into the seconds bit
        set_count(16'h7FFF, 16'h0000, 16'h0000);
        run_ticks(1);
        read_count(cnt);
        check("R2 tick into seconds bit", cnt, 48'h0000_0000_8000);

        // R2: carry ripples through two halfwords
        set_count(16'hFFFF, 16'hFFFF, 16'h0001);
        run_ticks(1);
        read_count(cnt);
        check("R2 carry across halfwords", cnt, 48'h0002_0000_0000);

        // R2: full wrap
        set_count(16'hFFFF, 16'hFFFF, 16'hFFFF);
        run_ticks(1);
        read_count(cnt);
        check("R2 wrap to zero", cnt, 48'h0);

        // R3: no ticks means no change
        set_count(16'h0123, 16'h4567, 16'h89AB);
        repeat (5) @(negedge clk);
        read_count(cnt);
        check("R3 hold without tick", cnt, 48'h89AB_4567_0123);

        // R4: write in the same cycle as a tick overrides that halfword only
        set_count(16'hFFFF, 16'h0000, 16'h0007);
        @(negedge clk);
        tick_en = 1'b1; bus_win = 1'b0; bus_addr = 5'h02; bus_wdata = 16'hAAAA; bus_we = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0;
        read_count(cnt);
        check("R4 write overrides one halfword", cnt, 48'h0007_AAAA_0000);

        // R6: alarm lands exactly on the tick that reaches the compare
        bus_write(1'b0, 5'h08, 16'h0003);
        bus_write(1'b0, 5'h0a, 16'h0010);
        bus_write(1'b0, 5'h0c, 16'h0000);
        set_count(16'h0000, 16'h0010, 16'h0000);
        bus_write(1'b1, 5'h1e, 16'h0001);
        flag_en = 1'b1;
        run_ticks(2);
        read_flag(rd);
        check("R6 no flag one tick before match", {32'h0, rd}, 48'h0);
        run_ticks(1);
        read_flag(rd);
        check("R6 flag on match", {32'h0, rd}, 48'h1);
        check("R9 irq with enable", {47'h0, irq}, 48'h1);

        // R9: gating by enable
        flag_en = 1'b0;
        #1;
        check("R9 irq masked", {47'h0, irq}, 48'h0);
        flag_en = 1'b1;

        // R8: write zero keeps the flag, write one clears it
        bus_write(1'b1, 5'h1e, 16'h0000);
        read_flag(rd);
        check("R8 write zero keeps flag", {32'h0, rd}, 48'h1);
        bus_write(1'b1, 5'h1e, 16'h0001);
        read_flag(rd);
        check("R8 write one clears flag", {32'h0, rd}, 48'h0);

        // R7: count held on the compare value does not re-raise the flag
        repeat (4) @(negedge clk);
        read_flag(rd);
        check("R7 no re-fire while equal", {32'h0, rd}, 48'h0);
        bus_write(1'b0, 5'h08, 16'h0003);
        repeat (2) @(negedge clk);
        read_flag(rd);
        check("R7 equal compare write no flag", {32'h0, rd}, 48'h0);

        // R8: set and clear in one cycle, set wins
        bus_write(1'b0, 5'h08, 16'h0005);
        run_ticks(2);
        read_flag(rd);
        check("R8 flag raised at 5", {32'h0, rd}, 48'h1);
        bus_write(1'b0, 5'h08, 16'h0007);
        run_ticks(1);
        @(negedge clk);
        tick_en = 1'b1; bus_win = 1'b1; bus_addr = 5'h1e; bus_wdata = 16'h0001; bus_we = 1'b1;
        @(negedge clk);
        tick_en = 1'b0; bus_we = 1'b0;
        read_flag(rd);
        check("R8 set beats clear", {32'h0, rd}, 48'h1);

        // R10: torn read across a carry, found by reading twice
        set_count(16'hFFFF, 16'h0003, 16'h0000);
        bus_read(1'b0, 5'h00, rd);
        run_ticks(1);
        bus_read(1'b0, 5'h02, rd2);
        first_val = {16'h0, rd2, rd};
        check("R10 torn first read", first_val, 48'h0000_0004_FFFF);
        bus_read(1'b0, 5'h00, rd);
        bus_read(1'b0, 5'h02, rd2);
        second_val = {16'h0, rd2, rd};
        check("R10 double read detects tear", {47'h0, first_val != second_val}, 48'h1);
        check("R10 second read consistent", second_val, 48'h0000_0004_0000);

        // R11: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; tick_en = 1'b0;
        read_count(cnt);
        check("R11 count after mid-run reset", cnt, 48'h0);
        read_flag(rd);
        check("R11 flag after mid-run reset", {32'h0, rd}, 48'h0);
        bus_read(1'b0, 5'h0a, rd);
        check("R11 compare after mid-run reset", {32'h0, rd}, 48'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule